// File: doc/BRIEF.md
# Indirect Meter Parameter Access Port

This block gives software access to a table of per-queue rate-meter settings through a three-register window, rather than one register per setting. Each table entry is named by a parameter type, a meter group and a meter index. Software places those fields in one command word, together with a direction bit. The block then carries out the table access over a fixed number of cycles. When the access is finished it raises a completion flag in the same command word, and software polls that flag.

To store a value, software first loads the low data word and then issues a write command. To fetch a value, software issues a read command, polls for completion, and then reads the low and high data words. The block holds three parameter kinds for every meter: a mode word, a token rate and a bucket-size shift. A separate read-only view port lets the meter datapath look at any stored entry at any time.

Top module: `meter_param_port`

## Requirements
- R1: After reset, every register in the window reads zero, including the completion flag. Every stored parameter also reads zero on the view port.
- R2: The command register sits at offset 0x0. Bit 31 is the direction (1 = write, 0 = read). Bits 29:28 are the type (0 = mode, 1 = token rate, 2 = bucket shift). Bits 27:26 are the group and bits 23:16 are the index. These fields read back as written. Bits 25:24 and 15:0 always read zero. Bit 30 cannot be written and reports completion.
- R3: A command write clears the completion flag (bit 30) on the clock edge that takes the command. The flag stays low for exactly LAT-1 further edges and is set on the LAT-th edge after the command (LAT defaults to 3). The flag is never set in the cycle in which the command is written.
- R4: A completed write command copies the low data word into the entry chosen by type, group and index. The new value appears on the view port.
- R5: A completed read command loads the chosen entry into the low data word and clears the high data word.
- R6: The three types hold independent storage. Writing one type leaves the other two types of the same meter unchanged.
- R7: A command with type code 3 still completes and sets the flag. It changes no entry, and a read with type 3 returns zero in the low data word.
- R8: A command whose index is NUM_IDX or above (NUM_IDX defaults to 8) completes like a type-3 command. It changes no entry and reads return zero.
- R9: The high data word at offset 0xC can be written by software and reads back the written value until a read command completes.
- R10: The low data word sits at offset 0x8 and reads back what software wrote. Any other offset reads zero, and writes to it have no effect.
- R11: For any group and index inside the table, the view port shows the stored mode, rate and shift values combinationally. For an index outside the table it shows zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| view_grp | input | 2 | Group chosen for the view port |
| view_idx | input | 8 | Index chosen for the view port |
| view_mode | output | 32 | Stored mode word of the viewed meter |
| view_rate | output | 32 | Stored token rate of the viewed meter |
| view_shift | output | 32 | Stored bucket shift of the viewed meter |

## Verification
The bench counts the edges between a command write and the rise of the completion flag. A design that sets the flag early, too late, or on the command edge itself fails that check. It also writes all three types at the same meter and reads each one back. A design that shares storage across types, or ignores the type field, returns the wrong word. It then issues type-3 and out-of-range-index commands with a non-zero low data word and looks for a changed entry on the view port or a non-zero read result. Last, it checks the reserved command bits and the unused offset, and confirms that a completed read clears a high data word that software had loaded.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;
    localparam int GRP_W  = 2;
    localparam int IDX_W  = 8;
    localparam int NTYPES = 3;

    localparam logic [ADDR_W-1:0] OFS_CMD = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_LO  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_HI  = 4'hC;

    typedef enum logic [1:0] {
        PT_MODE  = 2'd0,
        PT_RATE  = 2'd1,
        PT_SHIFT = 2'd2,
        PT_NONE  = 2'd3
    } ptype_e;

    typedef struct packed {
        logic             wr;
        ptype_e           ptype;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] idx;
    } cmd_s;

    function automatic cmd_s cmd_unpack(input logic [WORD_W-1:0] w);
        cmd_s c;
        c.wr    = w[31];
        c.ptype = ptype_e'(w[29:28]);
        c.grp   = w[27:26];
        c.idx   = w[23:16];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cmd_pack(input cmd_s c, input logic done);
        return {c.wr, done, c.ptype, c.grp, 2'b00, c.idx, 16'h0000};
    endfunction

endpackage

// File: rtl/mpa_seq.sv
module mpa_seq #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic fire,
    output logic done
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    assign fire = busy_q && (cnt_q == CNT_W'(1));
    assign busy = busy_q;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= CNT_W'(LAT);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (fire) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        start |=> !done_q); // R3

    AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !done_q); // R3

endmodule

// File: rtl/mpa_table.sv
module mpa_table
    import mpa_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int NUM_IDX = 8,
    parameter int DW      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  ptype_e           ptype,
    input  logic [GRP_W-1:0] grp,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic             hit,
    output logic [DW-1:0]    rdata,
    input  logic [GRP_W-1:0] view_grp,
    input  logic [IDX_W-1:0] view_idx,
    output logic [DW-1:0]    view_mode,
    output logic [DW-1:0]    view_rate,
    output logic [DW-1:0]    view_shift
);
    localparam int NUM_ENT = NUM_GRP * NUM_IDX;
    localparam int ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic             acc_ok, view_ok;
    logic [ENT_W-1:0] acc_ent, view_ent;
    logic [DW-1:0]    rd_arr   [NTYPES];
    logic [DW-1:0]    view_arr [NTYPES];

    assign acc_ok   = (32'(grp) < NUM_GRP) && (32'(idx) < NUM_IDX);
    assign view_ok  = (32'(view_grp) < NUM_GRP) && (32'(view_idx) < NUM_IDX);
    assign hit      = acc_ok && (ptype != PT_NONE);
    assign acc_ent  = ENT_W'(32'(grp) * NUM_IDX + 32'(idx));
    assign view_ent = ENT_W'(32'(view_grp) * NUM_IDX + 32'(view_idx));

    for (genvar t = 0; t < NTYPES; t++) begin : g_type
        logic [DW-1:0] mem [NUM_ENT];
        logic          we_t;

        assign we_t = we && hit && (2'(ptype) == 2'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int e = 0; e < NUM_ENT; e++) begin
                    mem[e] <= '0;
                end
            end else if (we_t) begin
                mem[acc_ent] <= wdata;
            end
        end

        assign rd_arr[t]   = acc_ok  ? mem[acc_ent]  : '0;
        assign view_arr[t] = view_ok ? mem[view_ent] : '0;
    end

    always_comb begin
        unique case (ptype)
            PT_MODE:  rdata = rd_arr[0];
            PT_RATE:  rdata = rd_arr[1];
            PT_SHIFT: rdata = rd_arr[2];
            default:  rdata = '0;
        endcase
    end

    assign view_mode  = view_arr[0];
    assign view_rate  = view_arr[1];
    assign view_shift = view_arr[2];

endmodule

// File: rtl/meter_param_port.sv
module meter_param_port
    import mpa_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int NUM_IDX = 8,
    parameter int LAT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [GRP_W-1:0]  view_grp,
    input  logic [IDX_W-1:0]  view_idx,
    output logic [WORD_W-1:0] view_mode,
    output logic [WORD_W-1:0] view_rate,
    output logic [WORD_W-1:0] view_shift
);
    cmd_s              cmd_q;
    logic [WORD_W-1:0] lo_q, hi_q;
    logic              cmd_we, lo_we, hi_we;
    logic              busy, fire, done;
    logic              tbl_hit;
    logic [WORD_W-1:0] tbl_rd;

    assign cmd_we = reg_wr && (reg_addr == OFS_CMD);
    assign lo_we  = reg_wr && (reg_addr == OFS_LO);
    assign hi_we  = reg_wr && (reg_addr == OFS_HI);

    mpa_seq #(.LAT(LAT)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (cmd_we),
        .busy  (busy),
        .fire  (fire),
        .done  (done)
    );

    mpa_table #(.NUM_GRP(NUM_GRP), .NUM_IDX(NUM_IDX), .DW(WORD_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .we         (fire && cmd_q.wr),
        .ptype      (cmd_q.ptype),
        .grp        (cmd_q.grp),
        .idx        (cmd_q.idx),
        .wdata      (lo_q),
        .hit        (tbl_hit),
        .rdata      (tbl_rd),
        .view_grp   (view_grp),
        .view_idx   (view_idx),
        .view_mode  (view_mode),
        .view_rate  (view_rate),
        .view_shift (view_shift)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            if (cmd_we) begin
                cmd_q <= cmd_unpack(reg_wdata);
            end
            if (fire && !cmd_q.wr) begin
                lo_q <= tbl_hit ? tbl_rd : '0;
                hi_q <= '0;
            end else begin
                if (lo_we) lo_q <= reg_wdata;
                if (hi_we) hi_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CMD: reg_rdata = cmd_pack(cmd_q, done);
            OFS_LO:  reg_rdata = lo_q;
            OFS_HI:  reg_rdata = hi_q;
            default: reg_rdata = '0;
        endcase
    end

    AST_HI_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd_q.wr) |=> (hi_q == '0)); // R5

    AST_LO_FROM_TABLE: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd_q.wr && tbl_hit) |=> (lo_q == $past(tbl_rd))); // R5

    AST_LO_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_q.wr && !lo_we) |=> (lo_q == $past(lo_q))); // R4

endmodule

// File: tb/meter_param_port_tb.sv
module meter_param_port_tb;
    localparam int CLK_PER = 10;
    localparam int LAT     = 3;
    localparam int NIDX    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  view_grp = '0;
    logic [7:0]  view_idx = '0;
    logic [31:0] view_mode, view_rate, view_shift;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    meter_param_port #(.NUM_GRP(4), .NUM_IDX(NIDX), .LAT(LAT)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .view_grp   (view_grp),
        .view_idx   (view_idx),
        .view_mode  (view_mode),
        .view_rate  (view_rate),
        .view_shift (view_shift)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic wr, input logic [1:0] t,
                                           input logic [1:0] g, input logic [7:0] i);
        return {wr, 1'b0, t, g, 2'b00, i, 16'h0000};
    endfunction

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v = '0;
        for (int i = 0; i < 40; i++) begin
            reg_read(4'h0, v);
            if (v[30]) break;
            @(negedge clk);
        end
        chk(req, 32'(v[30]), 32'd1);
    endtask

    task automatic param_write(input logic [1:0] t, input logic [1:0] g,
                               input logic [7:0] i, input logic [31:0] val);
        reg_write(4'h8, val);
        reg_write(4'h0, mk_cmd(1'b1, t, g, i));
        wait_done("R3");
    endtask

    task automatic param_read(input logic [1:0] t, input logic [1:0] g,
                              input logic [7:0] i, output logic [31:0] lo,
                              output logic [31:0] hi);
        reg_write(4'h0, mk_cmd(1'b0, t, g, i));
        wait_done("R3");
        reg_read(4'h8, lo);
        reg_read(4'hC, hi);
    endtask

    task automatic view_at(input logic [1:0] g, input logic [7:0] i);
        view_grp = g; view_idx = i;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(4'h0, v); chk("R1 cmd", v, 32'h0);
        reg_read(4'h8, v); chk("R1 lo", v, 32'h0);
        reg_read(4'hC, v); chk("R1 hi", v, 32'h0);
        view_at(2'd3, 8'd7);
        chk("R1 view", view_mode | view_rate | view_shift, 32'h0);
    endtask

    task automatic t_cmd_fields;
        logic [31:0] v;
        reg_write(4'h0, 32'hFFFF_FFFF);
        reg_read(4'h0, v);
        chk("R2 readback", v, 32'hBCFF_0000);
        wait_done("R7");
        reg_read(4'h0, v);
        chk("R2 done bit", v, 32'hFCFF_0000);
    endtask

    task automatic t_latency;
        logic [31:0] v;
        reg_write(4'h0, mk_cmd(1'b0, 2'd0, 2'd0, 8'd0));
        reg_read(4'h0, v);
        chk("R3 cleared on command", 32'(v[30]), 32'd0);
        for (int k = 1; k < LAT; k++) begin
            @(negedge clk);
            reg_read(4'h0, v);
            chk("R3 still low", 32'(v[30]), 32'd0);
        end
        @(negedge clk);
        reg_read(4'h0, v);
        chk("R3 set after LAT", 32'(v[30]), 32'd1);
    endtask

    task automatic t_write_read;
        logic [31:0] lo, hi;
        param_write(2'd0, 2'd1, 8'd3, 32'h1234_5678);
        view_at(2'd1, 8'd3);
        chk("R4 view mode", view_mode, 32'h1234_5678);
        reg_write(4'hC, 32'hDEAD_BEEF);
        reg_read(4'hC, hi);
        chk("R9 hi readback", hi, 32'hDEAD_BEEF);
        param_read(2'd0, 2'd1, 8'd3, lo, hi);
        chk("R5 lo", lo, 32'h1234_5678);
        chk("R5 hi cleared", hi, 32'h0);
    endtask

    task automatic t_types;
        logic [31:0] lo, hi;
        param_write(2'd1, 2'd1, 8'd3, 32'h0000_A5A5);
        param_write(2'd2, 2'd1, 8'd3, 32'h0000_0005);
        param_read(2'd0, 2'd1, 8'd3, lo, hi);
        chk("R6 mode kept", lo, 32'h1234_5678);
        param_read(2'd1, 2'd1, 8'd3, lo, hi);
        chk("R6 rate", lo, 32'h0000_A5A5);
        param_read(2'd2, 2'd1, 8'd3, lo, hi);
        chk("R6 shift", lo, 32'h0000_0005);
    endtask

    task automatic t_type3;
        logic [31:0] lo, hi;
        param_write(2'd3, 2'd1, 8'd3, 32'hFFFF_FFFF);
        view_at(2'd1, 8'd3);
        chk("R7 mode unchanged", view_mode, 32'h1234_5678);
        chk("R7 rate unchanged", view_rate, 32'h0000_A5A5);
        chk("R7 shift unchanged", view_shift, 32'h0000_0005);
        param_read(2'd3, 2'd1, 8'd3, lo, hi);
        chk("R7 read zero", lo, 32'h0);
    endtask

    task automatic t_range;
        logic [31:0] lo, hi;
        param_write(2'd1, 2'd0, 8'(NIDX), 32'h0000_0077);
        view_at(2'd0, 8'd0);
        chk("R8 entry 0 untouched", view_rate, 32'h0);
        view_at(2'd0, 8'(NIDX));
        chk("R11 view out of range", view_rate, 32'h0);
        param_read(2'd1, 2'd0, 8'(NIDX), lo, hi);
        chk("R8 read zero", lo, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        reg_write(4'h4, 32'h5555_AAAA);
        reg_read(4'h4, v);
        chk("R10 gap offset", v, 32'h0);
        reg_write(4'h8, 32'h0BAD_F00D);
        reg_read(4'h8, v);
        chk("R10 lo readback", v, 32'h0BAD_F00D);
        reg_write(4'hC, 32'h0000_1111);
        reg_read(4'hC, v);
        chk("R9 hi rewrite", v, 32'h0000_1111);
    endtask

    task automatic t_corner_entry;
        param_write(2'd1, 2'd3, 8'(NIDX - 1), 32'h0000_CAFE);
        view_at(2'd3, 8'(NIDX - 1));
        chk("R11 last entry rate", view_rate, 32'h0000_CAFE);
        chk("R11 last entry mode", view_mode, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL WDOG: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cmd_fields();
        t_latency();
        t_write_read();
        t_types();
        t_type3();
        t_range();
        t_map();
        t_corner_entry();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule